// File: doc/BRIEF.md
# Core Thread-Partition Mode Controller

This block decides how an eight-thread core is divided into subcores. It keeps one small control and status register and watches a per-thread nap vector. It drives two outputs: the number of subcores per core, and, for every thread, the index of the subcore that thread belongs to. Threads are grouped into contiguous blocks. In 2-way mode threads 0-3 form subcore 0 and threads 4-7 form subcore 1. In 4-way mode each aligned pair of threads forms one subcore, numbered 0 to 3.

Software requests a split by writing a request bit while the core is unsplit. It then polls the status bits to see when the split has taken place. Software never commands an unsplit. The controller merges the core back into one partition by itself when two things hold at once: the merge-disable bit is clear, and every thread except thread 0 reports nap. Setting the merge-disable bit prevents any automatic merge.

The mode machine has three states:
- UNSPLIT: 1 subcore.
- SPLIT2: 2 subcores.
- SPLIT4: 4 subcores.

It has four transitions:
- T_SPLIT2: UNSPLIT to SPLIT2, on a valid 2-way request.
- T_SPLIT4: UNSPLIT to SPLIT4, on a valid 4-way request.
- T_MERGE2: SPLIT2 to UNSPLIT, on the merge condition.
- T_MERGE4: SPLIT4 to UNSPLIT, on the merge condition.

Any other event leaves the state unchanged.

Register layout:
- Writes use `wr_data`:
  - bit 0 is the merge-disable bit, which can be read back.
  - bit 1 requests a 2-way split.
  - bit 2 requests a 4-way split.
- Reads use `rd_data`:
  - bit 0 is the merge-disable bit.
  - bits 1 and 2 are the request bits, which always read 0.
  - bit 3 is the 2-way status bit.
  - bit 4 is the 4-way status bit.

Top module: `subcore_partition_ctrl`

## Requirements
- R1: `subcores_per_core` reads 1 in UNSPLIT, 2 in SPLIT2 and 4 in SPLIT4.
- R2: `subcore_idx` packs 2 bits per thread, with thread t at bits [2t+1:2t]. In SPLIT2, threads 0-3 carry index 0 and threads 4-7 carry index 1. In SPLIT4, thread t carries index t/2.
- R3: The mode never goes directly from SPLIT2 to SPLIT4, or from SPLIT4 to SPLIT2. A split request written while the core is split leaves the mode unchanged.
- R4: When the merge-disable bit is clear and nap bits 7..1 are all 1, the mode becomes UNSPLIT. Nap bit 0 has no effect. If the condition is sampled at clock edge k, the new mode is visible after edge k+1.
- R5: While `rd_data[0]` (merge-disable) reads 1, a split mode is never left.
- R6: A write with `wr_en`=1 at edge k, made in UNSPLIT with exactly one request bit set, moves the mode as follows, visible after edge k+1:
  - `wr_data[1]` moves it to SPLIT2.
  - `wr_data[2]` moves it to SPLIT4.
- R7: Status bits `rd_data[3]` (2-way) and `rd_data[4]` (4-way) are both 0 in UNSPLIT. Only the bit matching the current split mode reads 1.
- R8: Request bits are self-clearing: `rd_data[2:1]` always reads 0, and a request has effect only in the cycle after its write.
- R9: A write with both `wr_data[1]` and `wr_data[2]` set changes no mode.
- R10: `mode_changed` is high for exactly the cycles in which the mode differs from its value in the previous cycle, and is low otherwise.
- R11: After reset the mode is UNSPLIT, `rd_data` reads 0, `subcores_per_core` reads 1 and `mode_changed` is 0.
- R12: In UNSPLIT every field of `subcore_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Write data: bit 0 merge-disable, bit 1 2-way request, bit 2 4-way request |
| rd_data | output | 5 | Register read data: disable, request bits (always 0), 2-way status, 4-way status |
| nap | input | 8 | Per-thread nap indication |
| subcores_per_core | output | 3 | Current number of subcores: 1, 2 or 4 |
| subcore_idx | output | 16 | Subcore index of each thread, 2 bits per thread |
| mode_changed | output | 1 | Pulse in the cycle a new mode first shows |

## Verification
The assertions check on every cycle that the status bits are never both 1 (R7), that a split mode never jumps to the other split mode (R3), and that a split mode is never left while the disable bit reads 1 (R5). They also check that `mode_changed` lines up with status changes (R10), that the outputs agree with the status (R1), and that the indices are zero when unsplit (R12). Only the bench scenarios can show the exact two-edge latency of requests and merges (R4, R6), that nap bit 0 is ignored, and that requests made while split or with both bits set are dropped (R8, R9). The bench shows these by comparing against its own cycle model and against hand-computed values.

// File: rtl/subcore_pkg.sv
package subcore_pkg;
    typedef enum logic [1:0] {
        UNSPLIT = 2'd0,
        SPLIT2  = 2'd1,
        SPLIT4  = 2'd2
    } part_mode_e;

    localparam int MAX_SUB = 4;
    localparam int IDX_W   = $clog2(MAX_SUB);
    localparam int SPC_W   = $clog2(MAX_SUB) + 1;
    localparam int RD_W    = 5;
endpackage

// File: rtl/subcore_csr.sv
module subcore_csr (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic [2:0] wr_data,
    output logic merge_dis,
    output logic req2,
    output logic req4
);
    // disable bit is held; request bits live for one cycle only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            merge_dis <= 1'b0;
            req2      <= 1'b0;
            req4      <= 1'b0;
        end else begin
            if (wr_en) begin
                merge_dis <= wr_data[0];
            end
            req2 <= wr_en && wr_data[1];
            req4 <= wr_en && wr_data[2];
        end
    end
endmodule

// File: rtl/subcore_merge_detect.sv
module subcore_merge_detect #(
    parameter int THREADS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic merge_dis,
    input  logic [THREADS-1:0] nap,
    output logic merge_cond
);
    logic [THREADS-1:0] nap_masked;
    logic               others_napping;

    // thread 0 does not take part in the merge condition
    always_comb begin
        nap_masked     = nap | {{(THREADS-1){1'b0}}, 1'b1};
        others_napping = &nap_masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            merge_cond <= 1'b0;
        end else begin
            merge_cond <= others_napping && !merge_dis;
        end
    end
endmodule

// File: rtl/subcore_mode_fsm.sv
module subcore_mode_fsm
    import subcore_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req2,
    input  logic req4,
    input  logic merge_cond,
    input  logic merge_dis,
    output part_mode_e mode,
    output logic mode_changed,
    output logic [SPC_W-1:0] spc,
    output logic stat2,
    output logic stat4
);
    part_mode_e state_q;
    part_mode_e state_d;
    logic       changed_q;

    // next state: splits only from UNSPLIT, merge only when not disabled
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UNSPLIT: begin
                if (req2 && !req4) begin
                    state_d = SPLIT2;
                end else if (req4 && !req2) begin
                    state_d = SPLIT4;
                end
            end
            SPLIT2, SPLIT4: begin
                if (merge_cond && !merge_dis) begin
                    state_d = UNSPLIT;
                end
            end
            default: state_d = UNSPLIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= UNSPLIT;
            changed_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            changed_q <= (state_d != state_q);
        end
    end

    always_comb begin
        mode         = state_q;
        mode_changed = changed_q;
        spc          = SPC_W'(1);
        stat2        = 1'b0;
        stat4        = 1'b0;
        unique case (state_q)
            UNSPLIT: spc = SPC_W'(1);
            SPLIT2: begin
                spc   = SPC_W'(2);
                stat2 = 1'b1;
            end
            SPLIT4: begin
                spc   = SPC_W'(4);
                stat4 = 1'b1;
            end
            default: spc = SPC_W'(1);
        endcase
    end
endmodule

// File: rtl/subcore_thread_map.sv
module subcore_thread_map
    import subcore_pkg::*;
#(
    parameter int THREADS = 8
) (
    input  part_mode_e mode,
    output logic [THREADS*IDX_W-1:0] idx
);
    localparam int HALF    = THREADS / 2;
    localparam int QUARTER = THREADS / 4;

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        localparam int IDX2 = t / HALF;
        localparam int IDX4 = t / QUARTER;
        always_comb begin
            unique case (mode)
                SPLIT2:  idx[t*IDX_W +: IDX_W] = IDX_W'(IDX2);
                SPLIT4:  idx[t*IDX_W +: IDX_W] = IDX_W'(IDX4);
                default: idx[t*IDX_W +: IDX_W] = '0;
            endcase
        end
    end
endmodule

// File: rtl/subcore_partition_ctrl.sv
module subcore_partition_ctrl
    import subcore_pkg::*;
#(
    parameter int THREADS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic [2:0] wr_data,
    output logic [RD_W-1:0] rd_data,
    input  logic [THREADS-1:0] nap,
    output logic [SPC_W-1:0] subcores_per_core,
    output logic [THREADS*IDX_W-1:0] subcore_idx,
    output logic mode_changed
);
    logic       merge_dis;
    logic       req2;
    logic       req4;
    logic       merge_cond;
    logic       stat2;
    logic       stat4;
    part_mode_e mode;

    subcore_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .merge_dis (merge_dis),
        .req2      (req2),
        .req4      (req4)
    );

    subcore_merge_detect #(.THREADS(THREADS)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .merge_dis  (merge_dis),
        .nap        (nap),
        .merge_cond (merge_cond)
    );

    subcore_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req2         (req2),
        .req4         (req4),
        .merge_cond   (merge_cond),
        .merge_dis    (merge_dis),
        .mode         (mode),
        .mode_changed (mode_changed),
        .spc          (subcores_per_core),
        .stat2        (stat2),
        .stat4        (stat4)
    );

    subcore_thread_map #(.THREADS(THREADS)) u_map (
        .mode (mode),
        .idx  (subcore_idx)
    );

    // request bits always read back as zero
    assign rd_data = {stat4, stat2, 2'b00, merge_dis};
endmodule

// File: rtl/subcore_partition_checks.sv
module subcore_partition_checks
    import subcore_pkg::*;
#(
    parameter int THREADS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic [RD_W-1:0] rd_data,
    input logic [SPC_W-1:0] subcores_per_core,
    input logic [THREADS*IDX_W-1:0] subcore_idx,
    input logic mode_changed
);
    p_status_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_data[4:3]));

    p_no_cross_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |=> !rd_data[4]);

    p_no_cross_split4_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |=> !rd_data[3]);

    p_no_merge_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && (rd_data[3] || rd_data[4])) |=> $stable(rd_data[4:3]));

    p_changed_on_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4:3] != $past(rd_data[4:3])) |-> mode_changed);

    p_changed_only_on_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_changed |-> (rd_data[4:3] != $past(rd_data[4:3])));

    p_spc_matches_r1: assert property (@(posedge clk) disable iff (!rst_n)
        subcores_per_core == (rd_data[4] ? 3'd4 : (rd_data[3] ? 3'd2 : 3'd1)));

    p_unsplit_idx_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[3] && !rd_data[4]) |-> (subcore_idx == '0));

    p_req_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2:1] == 2'b00);
endmodule

bind subcore_partition_ctrl subcore_partition_checks #(.THREADS(THREADS)) u_chk (.*);

// File: tb/sim_subcore_partition_ctrl.sv
`timescale 1ns/1ps
module sim_subcore_partition_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_data = 3'b000;
    logic [7:0]  nap = 8'h00;
    logic [4:0]  rd_data;
    logic [2:0]  subcores_per_core;
    logic [15:0] subcore_idx;
    logic        mode_changed;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    // model state: mode 0=unsplit 1=2-way 2=4-way
    int m_mode = 0;
    bit m_dis = 0, m_r2 = 0, m_r4 = 0, m_mc = 0, m_chg = 0;

    always #2 clk = ~clk;

    subcore_partition_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .nap(nap), .subcores_per_core(subcores_per_core),
        .subcore_idx(subcore_idx), .mode_changed(mode_changed)
    );

    function automatic logic [2:0] f_spc(int m);
        return (m == 1) ? 3'd2 : ((m == 2) ? 3'd4 : 3'd1);
    endfunction

    function automatic logic [15:0] f_idx(int m);
        logic [15:0] v = '0;
        for (int t = 0; t < 8; t++) begin
            if (m == 1) v[2*t +: 2] = 2'(t / 4);
            else if (m == 2) v[2*t +: 2] = 2'(t / 2);
        end
        return v;
    endfunction

    function automatic logic [4:0] f_rd(int m, bit d);
        return {m == 2, m == 1, 2'b00, d};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_dis = 0; m_r2 = 0; m_r4 = 0; m_mc = 0; m_chg = 0;
        end else begin
            int  nm;
            bit  nmc;
            nm = m_mode;
            if (m_mode != 0 && m_mc && !m_dis) nm = 0;
            else if (m_mode == 0 && (m_r2 ^ m_r4)) nm = m_r2 ? 1 : 2;
            nmc = !m_dis && (&nap[7:1]);
            m_chg = (nm != m_mode);
            m_mode = nm;
            m_mc = nmc;
            m_r2 = wr_en && wr_data[1];
            m_r4 = wr_en && wr_data[2];
            if (wr_en) m_dis = wr_data[0];
        end
    end

    // continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            check("R1 spc", 32'(subcores_per_core), 32'(f_spc(m_mode)));
            check(m_mode == 0 ? "R12 idx" : "R2 idx", 32'(subcore_idx), 32'(f_idx(m_mode)));
            check("R7 rd_data", 32'(rd_data), 32'(f_rd(m_mode, m_dis)));
            check("R10 mode_changed", 32'(mode_changed), 32'(m_chg));
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 3'b000;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        step(3);
        rst_n = 1'b1;
        step(1);
        chk_on = 1'b1;
        // R11 reset state
        check("R11 rd_data", 32'(rd_data), 0);
        check("R11 spc", 32'(subcores_per_core), 1);
        check("R11 changed", 32'(mode_changed), 0);
        check("R12 idx", 32'(subcore_idx), 0);

        // R6 2-way request, with disable set
        wr(3'b011);
        check("R6 no change yet", 32'(subcores_per_core), 1);
        step(1);
        check("R6 spc 2", 32'(subcores_per_core), 2);
        check("R6 status", 32'(rd_data), 32'h09);
        check("R10 pulse", 32'(mode_changed), 1);
        check("R2 idx 2way", 32'(subcore_idx), 32'h5500);
        step(1);
        check("R10 pulse ends", 32'(mode_changed), 0);

        // R8 / R3 4-way request while in 2-way ignored
        wr(3'b101);
        step(2);
        check("R3 stays 2way", 32'(subcores_per_core), 2);
        check("R8 req reads 0", 32'(rd_data[2:1]), 0);

        // R5 naps with disable set
        nap = 8'hFE;
        step(5);
        check("R5 no merge", 32'(subcores_per_core), 2);

        // R4 clear disable: merge two edges later, nap[0] is 0
        wr(3'b000);
        step(1);
        check("R4 not yet", 32'(subcores_per_core), 2);
        step(1);
        check("R4 merged", 32'(subcores_per_core), 1);
        check("R12 idx", 32'(subcore_idx), 0);

        // R9 both requests
        nap = 8'h00;
        wr(3'b111);
        step(2);
        check("R9 no change", 32'(subcores_per_core), 1);

        // R6 4-way, then R3 2-way request ignored
        wr(3'b101);
        step(1);
        check("R6 spc 4", 32'(subcores_per_core), 4);
        check("R2 idx 4way", 32'(subcore_idx), 32'hFA50);
        wr(3'b011);
        step(2);
        check("R3 stays 4way", 32'(subcores_per_core), 4);
        nap = 8'hFF;
        wr(3'b000);
        step(2);
        check("R4 merged from 4", 32'(subcores_per_core), 1);
        nap = 8'h00;
        step(2);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            wr_en = ($urandom % 4) == 0;
            wr_data = 3'($urandom);
            nap = (($urandom % 2) == 0) ? (8'hFE | 8'($urandom % 2)) : 8'($urandom);
            step(1);
        end
        wr_en = 1'b0;
        step(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule